// File: doc/BRIEF.md
# Three-Wire Register Load Port

This block receives configuration words for a dual-channel frequency synthesizer over a three-line serial link: a serial clock, a data line and a latch strobe. All three lines are asynchronous to the system clock. They are brought into the system clock domain by a synchronizer, and their edges are detected there. The system clock must run several times faster than the serial clock. Each rising serial clock edge shifts one data bit into a 22-bit shift register, most significant bit first.

When the strobe rises, the two least significant bits of the shifted word are decoded as a destination address. The complete word is then copied into one of four parallel latches. These latches hold, for example, the reference-divider and the dual-counter settings of each channel. A one-cycle load pulse marks which latch was written. A strobe that follows a bit count other than 22 is still acted on, using whatever the shift register holds at that moment, and it sets a sticky framing-error flag.

The control sequencer has three states:
- `S_IDLE`: no bits received since the last load.
- `S_SHIFT`: one or more bits received.
- `S_LOAD`: a single cycle in which the word is written.

Its transitions are:
- `S_IDLE` to `S_SHIFT` on a serial clock rise.
- `S_IDLE` to `S_LOAD` on a strobe rise.
- `S_SHIFT` to `S_LOAD` on a strobe rise.
- `S_LOAD` to `S_IDLE` unconditionally.

Top module: `cfg3w_port`

## Requirements
- R1: While reset is asserted and after its release, all four latches read zero, no load pulse is active and the framing-error flag is low.
- R2: A 22-bit frame shifted with the most significant bit first and then strobed appears unchanged in the addressed latch. The first bit sent lands in bit 21 and the last bit sent lands in bit 0.
- R3: The address is bits [1:0] of the shifted word. Address value k (0 to 3) selects latch k, which occupies bits [22k+21:22k] of the latch output bus.
- R4: A load writes only the addressed latch, and the other three latches keep their values.
- R5: Each strobe rise produces exactly one load pulse, one system cycle long. The pulse is one-hot on load_o, with the bit index equal to the address.
- R6: Shifting serial bits with the strobe held low changes no latch and produces no load pulse.
- R7: A strobe after fewer or more than 22 serial clocks still loads the current shift register contents, which are the most recent 22 bits shifted since reset. Bits not yet shifted since reset read as zero. The framing-error flag is set.
- R8: Once set, the framing-error flag stays high through later correct frames until reset.
- R9: A strobe after exactly 22 serial clocks leaves the framing-error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock; bits are taken on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_stb_i | input | 1 | Latch strobe; its rising edge loads the word |
| latch_o | output | 88 | Four 22-bit latches; latch k is at [22k+21:22k] |
| load_o | output | 4 | One-cycle one-hot load pulse, bit k for latch k |
| frame_err_o | output | 1 | Sticky flag for a strobe after a bit count other than 22 |

## Verification
The bench sends frames addressed to every latch in a shuffled order, with distinct data patterns. Walking and alternating bit patterns tell a correct bit order and alignment apart from reversed or shifted ones. A frame shifted with no strobe separates shifting from loading. A short frame and a long frame, each followed by a strobe, show that the word kept is the most recent 22 bits and that the error flag is raised. A later correct frame shows that the flag is sticky. A reset in the middle of the run shows that every latch and the flag clear.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SHIFT = 2'd1,
        S_LOAD  = 2'd2
    } ld_state_e;

endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    // STAGES flops for metastability, plus one more for edge detection
    logic [STAGES:0][WIDTH-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-1:0], async_i};
    end

    assign sync_o = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];
endmodule

// File: rtl/cfg3w_shift_fsm.sv
module cfg3w_shift_fsm
    import cfg3w_pkg::*;
#(
    parameter int WORD_W = 22,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_rise_i,
    input  logic              bit_val_i,
    input  logic              stb_rise_i,
    output logic              load_en_o,
    output logic [ADDR_W-1:0] load_addr_o,
    output logic [WORD_W-1:0] word_o,
    output logic              frame_err_o
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam int CNT_SAT = WORD_W + 1;

    ld_state_e         state_q, state_d;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (stb_rise_i) state_d = S_LOAD;
                     else if (bit_rise_i) state_d = S_SHIFT;
            S_SHIFT: if (stb_rise_i) state_d = S_LOAD;
            S_LOAD:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // shift register, bit counter and sticky framing flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            if (bit_rise_i)
                shreg_q <= {shreg_q[WORD_W-2:0], bit_val_i};
            if (state_q == S_LOAD)
                cnt_q <= bit_rise_i ? CNT_W'(1) : '0;
            else if (bit_rise_i && cnt_q != CNT_W'(CNT_SAT))
                cnt_q <= cnt_q + 1'b1;
            if (stb_rise_i && state_q != S_LOAD && cnt_q != CNT_W'(WORD_W))
                err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        load_en_o   = 1'b0;
        load_addr_o = shreg_q[ADDR_W-1:0];
        unique case (state_q)
            S_LOAD:  load_en_o = 1'b1;
            S_IDLE,
            S_SHIFT: load_en_o = 1'b0;
            default: load_en_o = 1'b0;
        endcase
    end

    assign word_o      = shreg_q;
    assign frame_err_o = err_q;
endmodule

// File: rtl/cfg3w_latch_bank.sv
module cfg3w_latch_bank #(
    parameter int WORD_W  = 22,
    parameter int ADDR_W  = 2,
    parameter int N_LATCH = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_en_i,
    input  logic [ADDR_W-1:0]         load_addr_i,
    input  logic [WORD_W-1:0]         word_i,
    output logic [N_LATCH*WORD_W-1:0] latch_o,
    output logic [N_LATCH-1:0]        pulse_o
);
    for (genvar k = 0; k < N_LATCH; k++) begin : g_latch
        logic              sel;
        logic [WORD_W-1:0] val_q;

        assign sel = load_en_i && (load_addr_i == ADDR_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   val_q <= '0;
            else if (sel) val_q <= word_i;
        end

        assign latch_o[k*WORD_W +: WORD_W] = val_q;
        assign pulse_o[k]                  = sel;
    end
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port #(
    parameter int WORD_W    = 22,
    parameter int ADDR_W    = 2,
    parameter int SYNC_STG  = 2,
    parameter int N_LATCH   = 1 << ADDR_W,
    parameter int LATCH_BUS = N_LATCH * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_data_i,
    input  logic                 ser_stb_i,
    output logic [LATCH_BUS-1:0] latch_o,
    output logic [N_LATCH-1:0]   load_o,
    output logic                 frame_err_o
);
    localparam int LINES = 3;

    logic [LINES-1:0]  line_s, line_p;
    logic              bit_rise, stb_rise;
    logic              load_en;
    logic [ADDR_W-1:0] load_addr;
    logic [WORD_W-1:0] word;

    cfg3w_sync #(.WIDTH(LINES), .STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_stb_i, ser_data_i, ser_clk_i}),
        .sync_o  (line_s),
        .prev_o  (line_p)
    );

    assign bit_rise = line_s[0] & ~line_p[0];
    assign stb_rise = line_s[2] & ~line_p[2];

    cfg3w_shift_fsm #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_rise_i  (bit_rise),
        .bit_val_i   (line_s[1]),
        .stb_rise_i  (stb_rise),
        .load_en_o   (load_en),
        .load_addr_o (load_addr),
        .word_o      (word),
        .frame_err_o (frame_err_o)
    );

    cfg3w_latch_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .N_LATCH(N_LATCH)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en_i   (load_en),
        .load_addr_i (load_addr),
        .word_i      (word),
        .latch_o     (latch_o),
        .pulse_o     (load_o)
    );
endmodule

// File: rtl/cfg3w_port_chk.sv
module cfg3w_port_chk #(
    parameter int WORD_W  = 22,
    parameter int ADDR_W  = 2,
    parameter int N_LATCH = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_LATCH*WORD_W-1:0] latch_o,
    input logic [N_LATCH-1:0]        load_o,
    input logic                      frame_err_o
);
    // R1: a cycle spent in reset leaves no pulse and a clear flag
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (load_o == '0 && !frame_err_o));

    // R3: after a pulse on bit k, latch k carries address k in its low bits
    for (genvar k = 0; k < N_LATCH; k++) begin : g_addr
        p_addr_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
            load_o[k] |=> latch_o[k*WORD_W +: ADDR_W] == ADDR_W'(k));
    end

    // R5: at most one latch pulses at a time, and never for two cycles running
    p_onehot_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_o));
    p_single_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_o) |=> (load_o == '0));

    // R4 and R6: with no pulse, no latch changes
    p_hold_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o == '0) |=> $stable(latch_o));

    // R8: the framing flag never falls outside reset
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> frame_err_o);
endmodule

bind cfg3w_port cfg3w_port_chk #(
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W),
    .N_LATCH (N_LATCH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_o     (latch_o),
    .load_o      (load_o),
    .frame_err_o (frame_err_o)
);

// File: tb/cfg3w_port_test.sv
`timescale 1ns/1ps
module cfg3w_port_test;
    localparam int W = 22;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic sclk = 1'b0, sdat = 1'b0, sstb = 1'b0;
    logic [N*W-1:0] latch_o;
    logic [N-1:0]   load_o;
    logic           frame_err_o;

    int total = 0, bad = 0, cyc = 0;
    logic [W-1:0] m_sh;
    logic [W-1:0] m_lat [N];
    logic         m_err;
    int           m_cnt;
    int           pulses [N];
    int           pulses_before [N];

    always #4 clk = ~clk;

    cfg3w_port uut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_data_i(sdat),
        .ser_stb_i(sstb), .latch_o(latch_o), .load_o(load_o),
        .frame_err_o(frame_err_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk)
        if (rst_n)
            for (int k = 0; k < N; k++) if (load_o[k]) pulses[k] <= pulses[k] + 1;

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_sh = '0; m_err = 1'b0; m_cnt = 0;
        for (int k = 0; k < N; k++) m_lat[k] = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
    endtask

    task automatic send_bits(input logic [31:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = val[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(5);
            sclk = 1'b0;
            wait_clk(4);
            m_sh = {m_sh[W-2:0], val[i]};
            m_cnt++;
        end
    endtask

    task automatic strobe();
        for (int k = 0; k < N; k++) pulses_before[k] = pulses[k];
        wait_clk(4);
        sstb = 1'b1;
        wait_clk(5);
        sstb = 1'b0;
        wait_clk(8);
        m_lat[m_sh[1:0]] = m_sh;
        if (m_cnt != W) m_err = 1'b1;
        m_cnt = 0;
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < N; k++)
            check(req, latch_o[k*W +: W], m_lat[k]);
        check({req, " err"}, W'(frame_err_o), W'(m_err));
    endtask

    task automatic check_pulses(input string req, input int addr);
        for (int k = 0; k < N; k++)
            check(req, W'(pulses[k] - pulses_before[k]), W'((k == addr) ? 1 : 0));
    endtask

    // R1
    task automatic t_reset();
        check("R1 load", W'(load_o), '0);
        check_all("R1");
    endtask

    // R2 R3 R4 R5 R9
    task automatic t_each_addr();
        logic [W-1:0] words [4];
        words[0] = 22'h2AAAA9 & ~22'h3 | 22'h3;
        words[1] = 22'h200000;
        words[2] = 22'h155556 & ~22'h3;
        words[3] = 22'h3C0F01;
        for (int i = 0; i < 4; i++) begin
            send_bits({10'd0, words[i]}, W);
            strobe();
            check_all("R2 R3 R4 R9");
            check_pulses("R5 pulse", int'(words[i][1:0]));
        end
    endtask

    // R6
    task automatic t_shift_no_strobe();
        for (int k = 0; k < N; k++) pulses_before[k] = pulses[k];
        send_bits({10'd0, 22'h1234_6}, W);
        check_all("R6");
        for (int k = 0; k < N; k++)
            check("R6 no pulse", W'(pulses[k] - pulses_before[k]), '0);
        strobe();
        check_all("R2 after R6");
        check_pulses("R5 pulse", 2);
    endtask

    // R7 R8
    task automatic t_short_then_good();
        send_bits(32'h000A_5A5D, 20);
        strobe();
        check_all("R7 short");
        check("R7 err", W'(frame_err_o), 22'd1);
        send_bits({10'd0, 22'h0F0F0E}, W);
        strobe();
        check_all("R8");
        check("R8 sticky", W'(frame_err_o), 22'd1);
    endtask

    // R1 R7
    task automatic t_reset_then_long();
        do_reset();
        check_all("R1 mid-run");
        send_bits(32'h0123_4567, 25);
        strobe();
        check_all("R7 long");
        check_pulses("R5 long pulse", int'(m_sh[1:0]));
    endtask

    initial begin
        rst_n = 1'b0;
        model_reset();
        for (int k = 0; k < N; k++) begin pulses[k] = 0; pulses_before[k] = 0; end
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_each_addr();
        t_shift_no_strobe();
        t_short_then_good();
        t_reset_then_long();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule